// File: doc/BRIEF.md
# SPI serial EEPROM target model

This block is a synthesizable SPI target that behaves like a small serial EEPROM of the 25-series kind. It runs on a fast system clock. It oversamples chip select, serial clock and serial data-in, and it decodes a one-byte opcode followed by an address of one, two or three bytes. It keeps a status byte that holds a busy flag, a write-enable latch and three storable protect bits. It serves reads from an internal byte array whose contents reset to 0xFF.

A write burst collects bytes into a page buffer. The address offset wraps inside the addressed page. When chip select rises, the collected bytes are committed and the busy flag stays up for a set number of clock cycles. At the end of that busy time the latch clears by itself. A host sets the latch before every write and polls the status byte until the busy flag drops.

The control path is a single state machine. Its states are IDLE (deselected), OPCODE (first byte), ADDR (address bytes), READ (streaming array data), LOAD (collecting write data), STAT_OUT (streaming status), STAT_IN (taking one status byte) and IGNORE (waiting for deselect). The transitions are as follows. Any state goes to IDLE whenever chip select is high. IDLE goes to OPCODE once chip select is low. OPCODE goes to STAT_OUT, STAT_IN, ADDR or IGNORE depending on the opcode, the busy flag and the latch. ADDR goes to READ or LOAD after the last address byte. STAT_IN goes to IGNORE after its one byte.

Top module: `spi_eeprom_model`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Bus timing is SPI mode 0: bits go MSB first, inputs are sampled on the rising clock edge, and output changes after the falling edge. Opcode 0x06 sets the latch (status bit 1) and opcode 0x04 clears it.
- R3: Opcode 0x05 returns the live status byte, repeated for as long as chip select stays low. In that byte, bit 0 is busy, bit 1 is the latch, bits 7, 3 and 2 are the protect bits, and all other bits read 0. Opcode 0x01 followed by one byte stores bits 7, 3 and 2 of that byte when chip select rises, but only if the latch is set. Storing them starts a busy period.
- R4: Opcode 0x02 with the latch clear changes nothing in the array or the status byte.
- R5: Data bytes of a write land at successive offsets. The offset wraps from the last byte of the addressed page to the first byte of the same page. The page size is 8 << PAGE_EXP bytes.
- R6: When chip select rises after at least one complete data byte, the write commits. Busy then reads 1 for BUSY_CYCLES clocks, and when busy drops the latch reads 0.
- R7: While busy is 1, every opcode except 0x05 is ignored.
- R8: Opcode 0x03 streams bytes from successive addresses while chip select stays low. The address wraps from the last array byte (size 128 << SIZE_EXP) to 0.
- R9: The address follows the opcode in ADDR_BYTES bytes, MSB first. When NINE_BIT is set, opcode bit 3 carries address bit 8 and is ignored when the opcode is decoded.
- R10: A transaction that ends inside the opcode or the address has no effect: no write, no busy period, and the latch is kept. A partly shifted final data byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when deselected |

## Verification
Page writes use start offsets and lengths that stay inside the page, run across the page end, and exceed the page size. A host model that resolves offsets sequentially then separates a correct in-page wrap from spill into the next page and from a lost overwrite. Reads that start near the array end show the difference between a wrap to zero and a stall. A second instance in nine-bit mode checks whether the opcode's address bit is honoured or decoded as part of the command. Transactions cut short, commands issued during busy, and writes without the latch each show whether the state changes when it must not.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_MEM_WR   = 8'h02;
    localparam logic [7:0] OP_MEM_RD   = 8'h03;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_LATCH_SET = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_READ,
        ST_LOAD,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_IGNORE
    } spi_state_e;
endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_rise,
    output logic cs_fall,
    output logic mosi_s
);
    logic sck_s1, sck_s2, cs_s1, cs_s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s1 <= 1'b0;
            sck_s2 <= 1'b0;
            cs_s1  <= 1'b1;
            cs_s2  <= 1'b1;
            mosi_s <= 1'b0;
        end else begin
            sck_s1 <= sck;
            sck_s2 <= sck_s1;
            cs_s1  <= cs_n;
            cs_s2  <= cs_s1;
            mosi_s <= mosi;
        end
    end

    assign sck_rise = sck_s1 & ~sck_s2;
    assign sck_fall = ~sck_s1 & sck_s2;
    assign cs_act   = ~cs_s1;
    assign cs_rise  = cs_s1 & ~cs_s2;
    assign cs_fall  = ~cs_s1 & cs_s2;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int AW = 11,
    parameter int PW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    input  logic            buf_we,
    input  logic [PW-1:0]   buf_off,
    input  logic [7:0]      buf_data,
    input  logic            buf_clear,
    input  logic            commit,
    input  logic [AW-PW-1:0] commit_page,
    output logic            buf_any
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    logic [7:0]      mem [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pmask;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_off] <= buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (buf_clear) pmask <= '0;
            if (buf_we) pmask[buf_off] <= 1'b1;
            if (commit) begin
                for (int i = 0; i < PAGE; i++) begin
                    if (pmask[i]) mem[{commit_page, PW'(i)}] <= pbuf[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign buf_any = |pmask;
endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model
    import spi_eeprom_pkg::*;
#(
    parameter int SIZE_EXP    = 4,
    parameter int PAGE_EXP    = 1,
    parameter int ADDR_BYTES  = 2,
    parameter bit NINE_BIT    = 1'b0,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int AW  = 7 + SIZE_EXP;
    localparam int PW  = 3 + PAGE_EXP;
    localparam int BCW = $clog2(BUSY_CYCLES + 1);

    logic sck_rise, sck_fall, cs_act, cs_rise, cs_fall, mosi_s;

    spi_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
        .cs_rise(cs_rise), .cs_fall(cs_fall), .mosi_s(mosi_s)
    );

    spi_state_e       state_q, state_d;
    logic [2:0]       bit_cnt_q;
    logic [6:0]       rx_q;
    logic [7:0]       tx_q;
    logic [AW-1:0]    addr_acc_q, rd_ptr_q;
    logic [1:0]       addr_left_q;
    logic             is_write_q;
    logic [AW-PW-1:0] wr_page_q;
    logic [PW-1:0]    wr_off_q;
    logic             latch_q, busy_q, pend_v_q;
    logic [BCW-1:0]   busy_cnt_q;
    logic [2:0]       prot_q, prot_pend_q;

    logic [7:0]    byte_in, op_key, rd_data, status;
    logic          byte_done, buf_we, buf_any, mem_commit, stat_commit;
    logic [AW-1:0] addr_next;

    assign byte_in     = {rx_q, mosi_s};
    assign byte_done   = sck_rise && (bit_cnt_q == 3'd7);
    assign op_key      = NINE_BIT ? (byte_in & 8'hF7) : byte_in;
    assign addr_next   = AW'({addr_acc_q, byte_in});
    assign status      = {prot_q[2], 3'b000, prot_q[1], prot_q[0], latch_q, busy_q};
    assign buf_we      = (state_q == ST_LOAD) && byte_done;
    assign mem_commit  = cs_rise && (state_q == ST_LOAD) && buf_any;
    assign stat_commit = cs_rise && pend_v_q;
    assign spi_miso    = tx_q[7];

    eeprom_array #(.AW(AW), .PW(PW)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_ptr_q), .rd_data(rd_data),
        .buf_we(buf_we), .buf_off(wr_off_q), .buf_data(byte_in),
        .buf_clear(cs_fall), .commit(mem_commit), .commit_page(wr_page_q),
        .buf_any(buf_any)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    if (busy_q && op_key != OP_STAT_RD) state_d = ST_IGNORE;
                    else if (op_key == OP_STAT_RD) state_d = ST_STAT_OUT;
                    else if (op_key == OP_STAT_WR) state_d = latch_q ? ST_STAT_IN : ST_IGNORE;
                    else if (op_key == OP_MEM_RD)  state_d = ST_ADDR;
                    else if (op_key == OP_MEM_WR)  state_d = latch_q ? ST_ADDR : ST_IGNORE;
                    else                           state_d = ST_IGNORE;
                end
                ST_ADDR:   if (byte_done && addr_left_q == 2'd1)
                               state_d = is_write_q ? ST_LOAD : ST_READ;
                ST_STAT_IN: if (byte_done) state_d = ST_IGNORE;
                ST_READ, ST_LOAD, ST_STAT_OUT, ST_IGNORE: state_d = state_q;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            addr_acc_q  <= '0;
            rd_ptr_q    <= '0;
            addr_left_q <= '0;
            is_write_q  <= 1'b0;
            wr_page_q   <= '0;
            wr_off_q    <= '0;
            latch_q     <= 1'b0;
            busy_q      <= 1'b0;
            busy_cnt_q  <= '0;
            pend_v_q    <= 1'b0;
            prot_q      <= '0;
            prot_pend_q <= '0;
        end else begin
            if (busy_q) begin
                busy_cnt_q <= busy_cnt_q - 1'b1;
                if (busy_cnt_q == BCW'(1)) begin
                    busy_q  <= 1'b0;
                    latch_q <= 1'b0;
                end
            end

            if (!cs_act) begin
                bit_cnt_q <= '0;
                tx_q      <= '0;
            end else begin
                if (sck_rise) begin
                    rx_q      <= byte_in[6:0];
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
                if (sck_fall) begin
                    if (bit_cnt_q == 3'd0 && state_q == ST_READ) begin
                        tx_q     <= rd_data;
                        rd_ptr_q <= rd_ptr_q + 1'b1;
                    end else if (bit_cnt_q == 3'd0 && state_q == ST_STAT_OUT) begin
                        tx_q <= status;
                    end else begin
                        tx_q <= {tx_q[6:0], 1'b0};
                    end
                end
            end

            if (state_q == ST_OPCODE && byte_done) begin
                addr_acc_q  <= NINE_BIT ? AW'(byte_in[3]) : '0;
                addr_left_q <= 2'(ADDR_BYTES);
                is_write_q  <= (op_key == OP_MEM_WR);
                if (!busy_q && op_key == OP_LATCH_SET) latch_q <= 1'b1;
                if (!busy_q && op_key == OP_LATCH_CLR) latch_q <= 1'b0;
            end

            if (state_q == ST_ADDR && byte_done) begin
                addr_acc_q  <= addr_next;
                addr_left_q <= addr_left_q - 1'b1;
                if (addr_left_q == 2'd1) begin
                    rd_ptr_q  <= addr_next;
                    wr_page_q <= addr_next[AW-1:PW];
                    wr_off_q  <= addr_next[PW-1:0];
                end
            end

            if (buf_we) wr_off_q <= wr_off_q + 1'b1;

            if (state_q == ST_STAT_IN && byte_done) begin
                prot_pend_q <= {byte_in[7], byte_in[3], byte_in[2]};
                pend_v_q    <= 1'b1;
            end

            if (cs_fall) pend_v_q <= 1'b0;

            if (stat_commit) begin
                prot_q   <= prot_pend_q;
                pend_v_q <= 1'b0;
            end

            if (mem_commit || stat_commit) begin
                busy_q     <= 1'b1;
                busy_cnt_q <= BCW'(BUSY_CYCLES);
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_checks.sv
module spi_eeprom_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       latch,
    input logic [2:0] prot,
    input logic       commit,
    input logic       cs_act,
    input logic       in_idle
);
    p_commit_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(latch));

    p_latch_drops_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !latch);

    p_prot_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(prot));

    p_no_commit_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy);

    p_idle_when_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cs_act) |-> in_idle);
endmodule

bind spi_eeprom_model spi_eeprom_checks u_checks (
    .clk(clk),
    .rst_n(rst_n),
    .busy(busy_q),
    .latch(latch_q),
    .prot(prot_q),
    .commit(mem_commit),
    .cs_act(cs_act),
    .in_idle(state_q == spi_eeprom_pkg::ST_IDLE)
);

// File: tb/test_spi_eeprom_model.sv
module test_spi_eeprom_model;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, cs0_n = 1'b1, cs1_n = 1'b1;
    logic miso0, miso1;
    int   dev_sel = 0;
    int   n_checks = 0, n_fail = 0;

    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];
    logic [7:0] mdl  [2][2048];

    always #2.5 clk = ~clk;

    spi_eeprom_model #(.SIZE_EXP(4), .PAGE_EXP(1), .ADDR_BYTES(2), .NINE_BIT(1'b0),
                       .BUSY_CYCLES(1000)) i_spi_eeprom_model (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs0_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso0));

    spi_eeprom_model #(.SIZE_EXP(2), .PAGE_EXP(0), .ADDR_BYTES(1), .NINE_BIT(1'b1),
                       .BUSY_CYCLES(1000)) i_spi_eeprom_model_nine (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs1_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso1));

    function automatic int pg_mask(int d);
        return (d == 0) ? 15 : 7;
    endfunction

    function automatic int arr_mask(int d);
        return (d == 0) ? 2047 : 511;
    endfunction

    function automatic int page_slot(int d, int base, int i);
        return (base & ~pg_mask(d)) | ((base + i) & pg_mask(d));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel(input bit on);
        if (dev_sel == 0) cs0_n = !on; else cs1_n = !on;
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = tx[i];
            repeat (4) @(negedge clk);
            rx[i] = (dev_sel == 0) ? miso0 : miso1;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic send_op_addr(input logic [7:0] op, input int addr);
        logic [7:0] d;
        if (dev_sel == 0) begin
            xfer(op, d);
            xfer(8'(addr >> 8), d);
            xfer(8'(addr), d);
        end else begin
            xfer(op | (8'((addr >> 8) & 1) << 3), d);
            xfer(8'(addr), d);
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(1); xfer(op, d); sel(0);
    endtask

    task automatic read_status(output logic [7:0] s);
        logic [7:0] d;
        sel(1); xfer(8'h05, d); xfer(8'h00, s); sel(0);
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int k = 0; k < 60; k++) begin
            read_status(s);
            if (!s[0]) break;
        end
    endtask

    task automatic mem_write(input int addr, input int n);
        logic [7:0] d;
        sel(1);
        send_op_addr(8'h02, addr);
        for (int i = 0; i < n; i++) xfer(wbuf[i], d);
        sel(0);
    endtask

    task automatic model_write(input int addr, input int n);
        for (int i = 0; i < n; i++) mdl[dev_sel][page_slot(dev_sel, addr, i)] = wbuf[i];
    endtask

    task automatic mem_read(input int addr, input int n);
        sel(1);
        send_op_addr(8'h03, addr);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        sel(0);
    endtask

    task automatic compare_read(input string req, input int addr, input int n);
        mem_read(addr, n);
        for (int i = 0; i < n; i++)
            check(req, rbuf[i], mdl[dev_sel][(addr + i) & arr_mask(dev_sel)]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int a, n;
        void'($urandom(32'd1234));
        for (int dv = 0; dv < 2; dv++)
            for (int i = 0; i < 2048; i++) mdl[dv][i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        read_status(s);
        check("R1 status", s, 8'h00);
        compare_read("R1 erased", 0, 4);

        // R4 write without latch
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        mem_write(16, 4);
        read_status(s);
        check("R4 no busy", s, 8'h00);
        compare_read("R4 unchanged", 16, 4);

        // R2 latch set and clear
        cmd1(8'h06);
        read_status(s);
        check("R2 set", s, 8'h02);
        cmd1(8'h04);
        read_status(s);
        check("R2 clear", s, 8'h00);

        // R5/R6/R7 page wrap, busy and ignore during busy
        cmd1(8'h06);
        for (int i = 0; i < 5; i++) wbuf[i] = 8'h30 + 8'(i);
        mem_write(30, 5);
        model_write(30, 5);
        read_status(s);
        check("R6 busy", s, 8'h03);
        cmd1(8'h04);
        sel(1); xfer(8'h01, d); xfer(8'h8C, d); sel(0);
        read_status(s);
        check("R7 latch held", s, 8'h03);
        wait_ready();
        read_status(s);
        check("R6 latch auto clear", s, 8'h00);
        compare_read("R5 wrap", 16, 16);
        compare_read("R5 next page", 32, 2);

        // R3 status write
        cmd1(8'h06);
        sel(1); xfer(8'h01, d); xfer(8'hFF, d); sel(0);
        wait_ready();
        read_status(s);
        check("R3 protect bits", s, 8'h8C);
        sel(1); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, d); sel(0);
        check("R3 repeated", d, 8'h8C);
        cmd1(8'h06);
        sel(1); xfer(8'h01, d); xfer(8'h00, d); sel(0);
        wait_ready();
        read_status(s);
        check("R3 cleared", s, 8'h00);

        // R10 truncated address, partial data byte
        cmd1(8'h06);
        sel(1); xfer(8'h02, d); xfer(8'h00, d); sel(0);
        read_status(s);
        check("R10 short addr", s, 8'h02);
        sel(1); send_op_addr(8'h02, 64); xfer(8'h5A, d); xfer_bits(8'hC3, 3, d); sel(0);
        mdl[0][64] = 8'h5A;
        wait_ready();
        compare_read("R10 partial byte", 64, 2);

        // R8 read wrap at array end
        cmd1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        mem_write(2046, 2);
        model_write(2046, 2);
        wait_ready();
        compare_read("R8 wrap", 2046, 4);

        // R5/R8 random page writes
        for (int k = 0; k < 10; k++) begin
            a = int'($urandom % 2048);
            n = 1 + int'($urandom % 20);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            cmd1(8'h06);
            mem_write(a, n);
            model_write(a, n);
            wait_ready();
            read_status(s);
            check("R6 random clear", s, 8'h00);
            compare_read("R5 random", (a & ~15) + 2032, 20);
        end

        // R9 nine-bit address mode
        dev_sel = 1;
        cmd1(8'h06);
        wbuf[0] = 8'h91; wbuf[1] = 8'h92; wbuf[2] = 8'h93;
        mem_write(261, 3);
        model_write(261, 3);
        wait_ready();
        compare_read("R9 high half", 261, 3);
        compare_read("R9 low half", 5, 3);
        cmd1(8'h06);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
        mem_write(510, 4);
        model_write(510, 4);
        wait_ready();
        compare_read("R9 R5 page", 504, 8);
        compare_read("R8 R9 wrap", 511, 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule